// File: doc/BRIEF.md
# Packet Buffer Transaction Controller

The controller sits between a register-mapped host port and a byte-serial radio framer. It keeps one transmit and one receive payload buffer, each sixteen bytes deep, and runs a whole packet exchange without host help. To send a packet, the host fills the transmit buffer, writes a length and sets a start bit. The block then hands the bytes to the framer one by one through a valid/ready handshake, with the length beside them. It marks the final byte, clears the start bit itself and posts a completion status.

On the receive side the framer pushes a stream of bytes. The first byte of each packet is its length, and the block uses it to find the end of the packet. The payload lands in the receive buffer. When the last byte arrives, the block records the length and raises a completion status. The host reads the length, which rewinds the read pointer, and then reads the payload byte by byte.

Four sticky status bits record transmit done, receive done, length error and receive overflow. Reading the status register clears them. Each bit can be routed to a single interrupt line through a mask register.

Top module: `pkt_txn_ctrl`

## Requirements
- R1: Bytes written to address 2 fill the transmit buffer from index 0; the index returns to 0 after every accepted start. After a length is written to address 1 and bit 0 is written as 1 to address 0, the block drives `tx_valid_o` with the buffered bytes in write order. `tx_len_o` carries the length, and `tx_last_o` is high only on the final byte.
- R2: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_data_o`, `tx_len_o` and `tx_valid_o` hold their values.
- R3: Bit 0 of address 0 reads 1 while a transmission is in progress and clears itself after the final byte is accepted. Status bit 0 (transmit done) then sets. A start request during a transmission has no effect.
- R4: A start request with a stored length of 0 or above 16 does not start a transmission. Status bit 2 (error) sets instead.
- R5: The first received byte of a packet is its length. The next length bytes are stored from index 0. After the last one, status bit 1 (receive done) sets and address 3 reads the length.
- R6: A received length of 0 or above 16 sets status bit 2. The block then discards that many following bytes, leaves the readable length unchanged, and takes the next byte as a new length.
- R7: Reading address 3 sets the receive read pointer to 0. Each read of address 4 returns the byte at the pointer and then advances it.
- R8: A valid length byte that arrives after a packet has completed, while address 3 has not yet been read, sets status bit 3 (overflow). The new packet then overwrites the buffer.
- R9: Reading address 5 returns the status bits in [3:0] and clears them. A status event in the same cycle as the read stays set.
- R10: `irq_o` is high exactly when some status bit and its mask bit at address 6 [3:0] are both set. The mask reads back at address 6.
- R11: After reset, status and mask are 0, `irq_o` and `tx_valid_o` are low, and address 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe; its side effects take place at the clock edge |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data, combinational from the address |
| irq_o | output | 1 | Masked interrupt |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | Framer accepts the transmit byte |
| tx_data_o | output | DW | Transmit byte |
| tx_len_o | output | DW | Length of the packet being sent |
| tx_last_o | output | 1 | Final byte of the packet |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | DW | Receive byte (length first, then payload) |

## Verification
A stale transmit index shows up as a wrong byte or a misplaced last flag on the framer port in the very cycle that byte is presented. A lost busy flag ends the stream early and sets the done status one cycle too soon. A receive state machine that mistakes a skipped byte for a length stores the wrong data, and the next status or length read shows it. A status bit that fails to clear, or fails to survive a same-cycle event, shows on `irq_o` in the following cycle. The reference model compares the interrupt, the transmit port and all read data on every clock, so most faults show up within one cycle of their cause.

// File: rtl/pkt_txn_pkg.sv
package pkt_txn_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_TXLEN  = 3'd1,
    A_TXDATA = 3'd2,
    A_RXLEN  = 3'd3,
    A_RXDATA = 3'd4,
    A_STAT   = 3'd5,
    A_MASK   = 3'd6
  } reg_addr_e;

  localparam int NSTAT     = 4;
  localparam int ST_TXDONE = 0;
  localparam int ST_RXDONE = 1;
  localparam int ST_ERR    = 2;
  localparam int ST_OVF    = 3;

  typedef enum logic [1:0] {RX_WAIT_LEN, RX_PAYLOAD, RX_DISCARD} rx_state_e;
endpackage

// File: rtl/pkt_tx_engine.sv
module pkt_tx_engine #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [DW-1:0] len_i,
  input  logic          go_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic [DW-1:0] tx_data_o,
  output logic [DW-1:0] tx_len_o,
  output logic          tx_last_o
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PADW = DW - AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [DW-1:0] len_q;
  logic          busy_q;
  logic          len_ok, accept, xfer, at_last;

  assign len_ok  = (len_i != '0) && (len_i <= DW'(DEPTH));
  assign accept  = go_i && !busy_q && len_ok;
  assign err_o   = go_i && !busy_q && !len_ok;
  assign at_last = ({{PADW{1'b0}}, rd_ptr_q} == len_q - 1'b1);
  assign xfer    = busy_q && tx_ready_i;
  assign done_o  = xfer && at_last;

  always_ff @(posedge clk_i) begin
    if (wr_i && !busy_q) mem[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      len_q    <= '0;
      busy_q   <= 1'b0;
    end else begin
      if (accept) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
        len_q    <= len_i;
        busy_q   <= 1'b1;
      end else begin
        if (wr_i && !busy_q) wr_ptr_q <= wr_ptr_q + 1'b1;
        if (xfer) begin
          rd_ptr_q <= rd_ptr_q + 1'b1;
          if (at_last) busy_q <= 1'b0;
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign tx_valid_o = busy_q;
  assign tx_data_o  = mem[rd_ptr_q];
  assign tx_len_o   = len_q;
  assign tx_last_o  = busy_q && at_last;

  p_hold_stalled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_len_o));
  p_bad_go_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i && !busy_q && !len_ok |=> !tx_valid_o);
  p_self_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/pkt_rx_engine.sv
module pkt_rx_engine
  import pkt_txn_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          len_rd_i,
  input  logic          data_rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] rx_len_o,
  output logic          done_o,
  output logic          err_o,
  output logic          ovf_o
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PADW = DW - AW;

  logic [DW-1:0] mem [DEPTH];
  rx_state_e     state_q;
  logic [DW-1:0] exp_q, skip_q, len_q;
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic          pending_q;
  logic          len_ok, start, in_payload;

  assign len_ok     = (rx_data_i != '0) && (rx_data_i <= DW'(DEPTH));
  assign start      = rx_valid_i && (state_q == RX_WAIT_LEN) && len_ok;
  assign err_o      = rx_valid_i && (state_q == RX_WAIT_LEN) && !len_ok;
  assign ovf_o      = start && pending_q;
  assign in_payload = rx_valid_i && (state_q == RX_PAYLOAD);
  assign done_o     = in_payload && ({{PADW{1'b0}}, wr_ptr_q} == exp_q - 1'b1);

  always_ff @(posedge clk_i) begin
    if (in_payload) mem[wr_ptr_q] <= rx_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RX_WAIT_LEN;
      exp_q    <= '0;
      skip_q   <= '0;
      len_q    <= '0;
      wr_ptr_q <= '0;
    end else if (rx_valid_i) begin
      unique case (state_q)
        RX_WAIT_LEN: begin
          if (len_ok) begin
            state_q  <= RX_PAYLOAD;
            exp_q    <= rx_data_i;
            wr_ptr_q <= '0;
          end else if (rx_data_i != '0) begin
            state_q <= RX_DISCARD;
            skip_q  <= rx_data_i;
          end
        end
        RX_PAYLOAD: begin
          wr_ptr_q <= wr_ptr_q + 1'b1;
          if (done_o) begin
            state_q <= RX_WAIT_LEN;
            len_q   <= exp_q;
          end
        end
        RX_DISCARD: begin
          skip_q <= skip_q - 1'b1;
          if (skip_q == DW'(1)) state_q <= RX_WAIT_LEN;
        end
        default: state_q <= RX_WAIT_LEN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      rd_ptr_q  <= '0;
    end else begin
      if (done_o)        pending_q <= 1'b1;
      else if (len_rd_i) pending_q <= 1'b0;
      if (len_rd_i)       rd_ptr_q <= '0;
      else if (data_rd_i) rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  assign rd_data_o = mem[rd_ptr_q];
  assign rx_len_o  = len_q;

  p_wr_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == RX_PAYLOAD |-> {{PADW{1'b0}}, wr_ptr_q} < exp_q);
  p_pending_after_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> pending_q);
  p_discard_keeps_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == RX_DISCARD |=> $stable(rx_len_o));
endmodule

// File: rtl/pkt_irq_status.sv
module pkt_irq_status #(
  parameter int NS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] set_i,
  input  logic          clr_i,
  input  logic          mask_we_i,
  input  logic [NS-1:0] mask_i,
  output logic [NS-1:0] status_o,
  output logic [NS-1:0] mask_o,
  output logic          irq_o
);
  logic [NS-1:0] status_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= (clr_i ? '0 : status_q) | set_i;
      if (mask_we_i) mask_q <= mask_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & mask_q);

  p_clear_on_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && (set_i == '0) |=> status_o == '0);
  p_event_survives_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |set_i |=> (status_o & $past(set_i)) == $past(set_i));
  p_irq_needs_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |mask_o);
endmodule

// File: rtl/pkt_txn_ctrl.sv
module pkt_txn_ctrl
  import pkt_txn_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic [DW-1:0] tx_data_o,
  output logic [DW-1:0] tx_len_o,
  output logic          tx_last_o,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i
);
  reg_addr_e     addr;
  logic [DW-1:0] txlen_q, rx_rd_data, rx_len;
  logic          tx_busy, tx_done, tx_err, rx_done, rx_err, rx_ovf;
  logic [NSTAT-1:0] status, mask, set;

  assign addr = reg_addr_e'(reg_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           txlen_q <= '0;
    else if (reg_we_i && addr == A_TXLEN) txlen_q <= reg_wdata_i;
  end

  pkt_tx_engine #(.DEPTH(DEPTH), .DW(DW)) u_tx (
    .clk_i, .rst_ni,
    .wr_i      (reg_we_i && addr == A_TXDATA),
    .wr_data_i (reg_wdata_i),
    .len_i     (txlen_q),
    .go_i      (reg_we_i && addr == A_CTRL && reg_wdata_i[0]),
    .busy_o    (tx_busy),
    .done_o    (tx_done),
    .err_o     (tx_err),
    .tx_valid_o, .tx_ready_i, .tx_data_o, .tx_len_o, .tx_last_o
  );

  pkt_rx_engine #(.DEPTH(DEPTH), .DW(DW)) u_rx (
    .clk_i, .rst_ni, .rx_valid_i, .rx_data_i,
    .len_rd_i  (reg_re_i && addr == A_RXLEN),
    .data_rd_i (reg_re_i && addr == A_RXDATA),
    .rd_data_o (rx_rd_data),
    .rx_len_o  (rx_len),
    .done_o    (rx_done),
    .err_o     (rx_err),
    .ovf_o     (rx_ovf)
  );

  always_comb begin
    set            = '0;
    set[ST_TXDONE] = tx_done;
    set[ST_RXDONE] = rx_done;
    set[ST_ERR]    = tx_err | rx_err;
    set[ST_OVF]    = rx_ovf;
  end

  pkt_irq_status #(.NS(NSTAT)) u_stat (
    .clk_i, .rst_ni,
    .set_i     (set),
    .clr_i     (reg_re_i && addr == A_STAT),
    .mask_we_i (reg_we_i && addr == A_MASK),
    .mask_i    (reg_wdata_i[NSTAT-1:0]),
    .status_o  (status),
    .mask_o    (mask),
    .irq_o
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (addr)
      A_CTRL:   reg_rdata_o[0] = tx_busy;
      A_TXLEN:  reg_rdata_o = txlen_q;
      A_RXLEN:  reg_rdata_o = rx_len;
      A_RXDATA: reg_rdata_o = rx_rd_data;
      A_STAT:   reg_rdata_o[NSTAT-1:0] = status;
      A_MASK:   reg_rdata_o[NSTAT-1:0] = mask;
      default:  reg_rdata_o = '0;
    endcase
  end

  p_reset_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> $past(reg_we_i));
endmodule

// File: tb/pkt_txn_ctrl_test.sv
module pkt_txn_ctrl_test;
  logic       clk = 0, rst_n = 0;
  logic       we = 0, re = 0, tx_ready = 0, rx_valid = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rx_data = 0, rdata, tx_data, tx_len;
  logic       irq, tx_valid, tx_last;
  int errors = 0, checks = 0, cycles = 0;
  bit rdy_auto = 0, rdy_fix = 1;
  logic [7:0] lfsr = 8'h5a;

  always #5 clk = ~clk;

  pkt_txn_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .tx_data_o(tx_data), .tx_len_o(tx_len), .tx_last_o(tx_last),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data)
  );

  // behavioural reference model
  logic [7:0] tbuf [16];
  logic [7:0] rbuf [16];
  logic [7:0] txq [$];
  logic [3:0] m_stat, m_mask;
  logic [7:0] m_txlen, m_curlen, m_rxlen, m_exp, m_cnt;
  int m_twp, m_rwp, m_rdp, m_rst;
  bit m_busy, m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_mask = 0; m_txlen = 0; m_curlen = 0; m_rxlen = 0;
      m_twp = 0; m_rwp = 0; m_rdp = 0; m_rst = 0; m_busy = 0; m_pend = 0;
      txq.delete();
    end else begin
      logic [3:0] set;
      bit busy_pre, pend_pre;
      set = 0; busy_pre = m_busy; pend_pre = m_pend;
      if (busy_pre && tx_ready) begin
        void'(txq.pop_front());
        if (txq.size() == 0) begin m_busy = 0; set[0] = 1; end
      end
      if (we) begin
        case (addr)
          3'd0: if (wdata[0] && !busy_pre) begin
            if (m_txlen >= 1 && m_txlen <= 16) begin
              txq.delete();
              for (int i = 0; i < m_txlen; i++) txq.push_back(tbuf[i]);
              m_curlen = m_txlen; m_busy = 1; m_twp = 0;
            end else set[2] = 1;
          end
          3'd1: m_txlen = wdata;
          3'd2: if (!busy_pre) begin tbuf[m_twp] = wdata; m_twp = (m_twp + 1) % 16; end
          3'd6: m_mask = wdata[3:0];
          default: ;
        endcase
      end
      if (rx_valid) begin
        if (m_rst == 0) begin
          if (rx_data >= 1 && rx_data <= 16) begin
            if (pend_pre) set[3] = 1;
            m_exp = rx_data; m_rwp = 0; m_rst = 1;
          end else begin
            set[2] = 1;
            if (rx_data != 0) begin m_cnt = rx_data; m_rst = 2; end
          end
        end else if (m_rst == 1) begin
          rbuf[m_rwp] = rx_data; m_rwp++;
          if (m_rwp == m_exp) begin set[1] = 1; m_rxlen = m_exp; m_rst = 0; m_pend = 1; end
        end else begin
          m_cnt--;
          if (m_cnt == 0) m_rst = 0;
        end
      end
      if (re && addr == 3'd3) begin
        m_rdp = 0;
        if (!set[1]) m_pend = 0;
      end
      if (re && addr == 3'd4) m_rdp = (m_rdp + 1) % 16;
      m_stat = ((re && addr == 3'd5) ? 4'h0 : m_stat) | set;
    end
  end

  function automatic logic [7:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return {7'b0, m_busy};
      3'd1: return m_txlen;
      3'd3: return m_rxlen;
      3'd4: return rbuf[m_rdp];
      3'd5: return {4'b0, m_stat};
      3'd6: return {4'b0, m_mask};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n) begin
    cycles++;
    chk("R10 irq", {7'b0, irq}, {7'b0, |(m_stat & m_mask)});
    chk("R3 tx_valid", {7'b0, tx_valid}, {7'b0, m_busy});
    if (m_busy) begin
      chk("R1 tx_data", tx_data, txq[0]);
      chk("R1 tx_last", {7'b0, tx_last}, {7'b0, txq.size() == 1});
      chk("R1 tx_len", tx_len, m_curlen);
    end
    if (re) chk("R7 R9 rdata", rdata, m_read(addr));
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready = rdy_auto ? lfsr[0] : rdy_fix;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    we = 1; addr = a; wdata = d; tick(); we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    re = 1; addr = a; #1; d = rdata; tick(); re = 0;
  endtask

  task automatic rx(logic [7:0] d);
    rx_valid = 1; rx_data = d; tick(); rx_valid = 0;
  endtask

  task automatic wait_idle();
    while (tx_valid) tick();
  endtask

  initial begin
    logic [7:0] v;
    tx_ready = 1;
    #12 rst_n = 1;
    tick();
    // R11 reset state
    chk("R11 irq", {7'b0, irq}, 8'h00);
    chk("R11 tx_valid", {7'b0, tx_valid}, 8'h00);
    rd(3'd5, v); chk("R11 status", v, 8'h00);
    rd(3'd6, v); chk("R11 mask", v, 8'h00);
    rd(3'd0, v); chk("R11 ctrl", v, 8'h00);

    // R10 mask readback
    wr(3'd6, 8'h0f);
    rd(3'd6, v); chk("R10 mask", v, 8'h0f);

    // R1, R3: five bytes with random framer stalls
    rdy_auto = 1;
    for (int i = 0; i < 5; i++) wr(3'd2, 8'h10 + 8'(i));
    wr(3'd1, 8'd5);
    wr(3'd0, 8'h01);
    rd(3'd0, v); chk("R3 busy", v, 8'h01);
    wr(3'd0, 8'h01); // ignored while busy
    wait_idle();
    rd(3'd0, v); chk("R3 self clear", v, 8'h00);
    rd(3'd5, v); chk("R3 tx done", v, 8'h01);
    rd(3'd5, v); chk("R9 cleared", v, 8'h00);

    // R2: stalled framer, then full 16-byte packet
    rdy_auto = 0; rdy_fix = 0;
    for (int i = 0; i < 16; i++) wr(3'd2, 8'ha0 ^ 8'(i * 7));
    wr(3'd1, 8'd16);
    wr(3'd0, 8'h01);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R2 held data", tx_data, 8'ha0);
      chk("R2 held valid", {7'b0, tx_valid}, 8'h01);
    end
    rdy_fix = 1;
    tick();
    wait_idle();
    rd(3'd5, v); chk("R3 done 16", v, 8'h01);

    // R4: bad lengths
    wr(3'd1, 8'd17); wr(3'd0, 8'h01);
    tick(); chk("R4 no start 17", {7'b0, tx_valid}, 8'h00);
    rd(3'd5, v); chk("R4 err 17", v, 8'h04);
    wr(3'd1, 8'd0); wr(3'd0, 8'h01);
    tick(); chk("R4 no start 0", {7'b0, tx_valid}, 8'h00);
    rd(3'd5, v); chk("R4 err 0", v, 8'h04);

    // R5, R7: receive four bytes
    rx(8'd4); rx(8'h31); rx(8'h32); rx(8'h33); rx(8'h34);
    rd(3'd5, v); chk("R5 rx done", v, 8'h02);
    rd(3'd3, v); chk("R5 rx len", v, 8'h04);
    rd(3'd4, v); chk("R7 byte0", v, 8'h31);
    rd(3'd4, v); chk("R7 byte1", v, 8'h32);
    rd(3'd3, v);
    rd(3'd4, v); chk("R7 rewind", v, 8'h31);

    // R6: oversize packet discarded, following packet parsed
    rx(8'd20);
    for (int i = 0; i < 20; i++) rx(8'd3);
    rx(8'd2); rx(8'h55); rx(8'h66);
    rd(3'd5, v); chk("R6 err+done", v, 8'h06);
    rd(3'd3, v); chk("R6 len", v, 8'h02);
    rd(3'd4, v); chk("R6 byte0", v, 8'h55);

    // R8: overflow
    rx(8'd1); rx(8'h77);
    rx(8'd1); rx(8'h88);
    rd(3'd5, v); chk("R8 ovf", v, 8'h0a);
    rd(3'd3, v);
    rd(3'd4, v); chk("R8 overwritten", v, 8'h88);

    // R9: event in same cycle as status read
    rd(3'd5, v);
    rx(8'd1);
    rx_valid = 1; rx_data = 8'h99; re = 1; addr = 3'd5; tick();
    rx_valid = 0; re = 0;
    rd(3'd5, v); chk("R9 same cycle", v, 8'h02);
    rd(3'd3, v);

    // R10: masking
    wr(3'd6, 8'h02);
    wr(3'd2, 8'h01); wr(3'd1, 8'd1); wr(3'd0, 8'h01);
    wait_idle(); tick();
    chk("R10 masked off", {7'b0, irq}, 8'h00);
    rx(8'd1); rx(8'h42);
    chk("R10 masked on", {7'b0, irq}, 8'h01);
    rd(3'd5, v); chk("R10 status", v, 8'h03);
    chk("R10 cleared", {7'b0, irq}, 8'h00);

    tick(); tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule